// File: doc/BRIEF.md
# Wraparound Burst Address Generator

This block produces the address for each beat of a four-word burst. When an access starts, the load strobe captures the whole starting address. The upper bits are held for the rest of the burst. The lowest two bits seed a sequence that moves one step each time the active-low advance input is low at a rising clock edge. When advance is high, the current address is held, which suspends the burst.

A static strap input selects the order of the sequence:

- **Linear order:** the low bits count up modulo four.
- **Interleaved order:** the low bits are the starting value XORed with a beat count that runs 0, 1, 2, 3.

In both orders the sequence wraps inside the aligned four-word group and never carries into the upper bits. The block does not know which strobe caused a load; the surrounding control logic decides that and pulses the load input.

The output address is registered. A load or an advance at one rising edge shows on the output just after that edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high at a rising edge, the output address becomes all zeros.
- R2: When load is high at a rising edge, the output after that edge equals the full address input at that edge.
- R3: With mode low (linear), each advance (adv_n low, load low) adds one to output bits [1:0] modulo 4. For example, start 01 gives 01, 10, 11, 00.
- R4: With mode high (interleaved), output bits [1:0] equal the loaded start value XOR the number of advances since the load, taken modulo 4. For example, start 10 gives 10, 11, 00, 01, and start 11 gives 11, 10, 01, 00.
- R5: After four advances, in either order, output bits [1:0] return to the value that was loaded.
- R6: When load is low and adv_n is high at a rising edge, the output address is unchanged (suspend).
- R7: Output bits above bit 1 keep the value captured at the last load until the next load.
- R8: When load and an advance coincide, the load wins. The output becomes the new address and the beat count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Starts a burst by capturing addr_in |
| adv_n | input | 1 | Active-low advance to the next beat |
| mode | input | 1 | Order strap: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | Starting address of the burst |
| burst_addr | output | ADDR_W | Address of the current beat |

## Verification
The bench runs all four start values in both orders. It inserts suspend cycles inside each burst and goes past four advances, so a design that drifts while suspended, or wraps to zero instead of to the start value, shows a wrong address. Interleaved bursts from 01 and 11 expose a design that adds instead of XORing, because those are the starts where the two orders diverge. A burst reloaded with advance held low would catch a design that lets advance win, or keeps the old beat count, because it would skip the first beat of the new burst. Random upper bits on every load reveal any carry out of bit 1 into the captured upper address.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        beat_t seed;
        beat_t count;
    } burst_state_t;

    function automatic beat_t order_low(order_e ord, beat_t seed, beat_t count);
        beat_t r;
        case (ord)
            ORD_INTERLEAVE: r = seed ^ count;
            default:        r = seed + count;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_addr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         adv_n,
    input  beat_t        seed_in,
    output burst_state_t state
);
    burst_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (load) begin
            state_q.seed  <= seed_in;
            state_q.count <= '0;
        end else if (!adv_n) begin
            state_q.count <= state_q.count + beat_t'(1);
        end
    end

    assign state = state_q;

    // R8
    load_restart_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (state.count == '0 && state.seed == $past(seed_in)));

    // R6
    suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && adv_n) |=> $stable(state));

    // R5
    seed_kept_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(state.seed));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_addr_pkg::*;
(
    input  order_e       ord,
    input  burst_state_t state,
    output beat_t        low
);
    assign low = order_low(ord, state.seed, state.count);
endmodule

// File: rtl/burst_upper_reg.sv
module burst_upper_reg #(
    parameter int UP_W = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [UP_W-1:0] d,
    output logic [UP_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    // R7
    upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv_n,
    input  logic              mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] burst_addr
);
    localparam int UP_W = ADDR_W - BEAT_W;

    order_e             ord;
    burst_state_t       state;
    beat_t              low;
    logic [UP_W-1:0]    upper;

    assign ord = order_e'(mode);

    burst_beat_ctr u_beat (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .adv_n   (adv_n),
        .seed_in (addr_in[BEAT_W-1:0]),
        .state   (state)
    );

    burst_order_map u_map (
        .ord   (ord),
        .state (state),
        .low   (low)
    );

    burst_upper_reg #(.UP_W(UP_W)) u_upper (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (addr_in[ADDR_W-1:BEAT_W]),
        .q    (upper)
    );

    assign burst_addr = {upper, low};

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (burst_addr == $past(addr_in)));

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (burst_addr == '0));
endmodule

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst, load, adv_n, mode;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] burst_addr;

    int errors = 0;
    int checks = 0;

    int m_up, m_seed, m_cnt;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .load(load), .adv_n(adv_n),
        .mode(mode), .addr_in(addr_in), .burst_addr(burst_addr)
    );

    function automatic int exp_low();
        if (mode) return m_seed ^ m_cnt;
        return (m_seed + m_cnt) % 4;
    endfunction

    task automatic check(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(logic ld, logic an, logic [AW-1:0] a, string req);
        load = ld; adv_n = an; addr_in = a;
        @(posedge clk);
        if (rst) begin
            m_up = 0; m_seed = 0; m_cnt = 0;
        end else if (ld) begin
            m_up = int'(a >> 2); m_seed = int'(a[1:0]); m_cnt = 0;
        end else if (!an) begin
            m_cnt = (m_cnt + 1) % 4;
        end
        @(negedge clk);
        check(req, burst_addr, AW'((m_up << 2) | exp_low()));
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: got hang expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [AW-1:0] base;
        string rq;
        rst = 1'b1; load = 1'b0; adv_n = 1'b1; mode = 1'b0; addr_in = '0;
        @(negedge clk);
        step(1'b0, 1'b1, '0, "R1");
        rst = 1'b0;
        step(1'b0, 1'b0, '0, "R1");

        for (int md = 0; md < 2; md++) begin
            mode = md[0];
            rq = md ? "R4" : "R3";
            for (int s = 0; s < 4; s++) begin
                base = {AW'($urandom) >> 2, 2'b00} | AW'(s);
                step(1'b1, 1'b1, base, "R2");
                step(1'b0, 1'b0, '0, rq);
                step(1'b0, 1'b1, '0, "R6");
                step(1'b0, 1'b1, '1, "R6");
                step(1'b0, 1'b0, '0, rq);
                step(1'b0, 1'b0, '0, rq);
                check("R7", burst_addr >> 2, base >> 2);
                step(1'b0, 1'b1, '0, "R6");
                step(1'b0, 1'b0, '0, "R5");
                check("R5", burst_addr, base);
                step(1'b0, 1'b0, '0, rq);
            end
        end

        // Fixed sequences named in the requirements
        mode = 1'b0;
        step(1'b1, 1'b1, 20'h00001, "R3");
        step(1'b0, 1'b0, '0, "R3"); check("R3", burst_addr, 20'h00002);
        step(1'b0, 1'b0, '0, "R3"); check("R3", burst_addr, 20'h00003);
        step(1'b0, 1'b0, '0, "R3"); check("R3", burst_addr, 20'h00000);
        mode = 1'b1;
        step(1'b1, 1'b1, 20'h0ABC3, "R4");
        step(1'b0, 1'b0, '0, "R4"); check("R4", burst_addr, 20'h0ABC2);
        step(1'b0, 1'b0, '0, "R4"); check("R4", burst_addr, 20'h0ABC1);
        step(1'b0, 1'b0, '0, "R4"); check("R4", burst_addr, 20'h0ABC0);
        step(1'b1, 1'b1, 20'h00002, "R4");
        step(1'b0, 1'b0, '0, "R4"); check("R4", burst_addr, 20'h00003);
        step(1'b0, 1'b0, '0, "R4"); check("R4", burst_addr, 20'h00000);

        // R8: load and advance together, mid-burst
        step(1'b1, 1'b0, 20'h12341, "R8");
        check("R8", burst_addr, 20'h12341);
        step(1'b0, 1'b0, '0, "R8");
        check("R8", burst_addr, 20'h12340);

        // R1 again mid-burst
        rst = 1'b1;
        step(1'b0, 1'b0, '0, "R1");
        check("R1", burst_addr, '0);
        rst = 1'b0;
        step(1'b0, 1'b1, '0, "R6");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule